// File: doc/BRIEF.md
# Constant-Word-Length Fractional Multiplier

This block multiplies two signed fractions of W bits each and returns a product of the same width and format. Each operand is in two's complement. The top bit is the sign and has weight -1. The bit that sits i places below it has weight 2^-i. Every value therefore lies in the range from -1 to 1 - 2^-(W-1).

Internally the block forms the exact product as a signed fraction of 2W-1 bits, using a sign-correct partial-product array. It then drops the W-1 lowest bits and keeps the upper W bits. The result is truncated toward negative infinity, with no rounding correction. One product, -1 times -1, equals +1 and cannot be represented. For that pair the result saturates to the largest positive word and an overflow flag is raised.

Operands arrive on a valid/ready stream and results leave on another. One register stage sits between them.

Back-pressure rules:
- A pair is taken on any clock where `in_valid` and `in_ready` are both high.
- A result is consumed on any clock where `out_valid` and `out_ready` are both high.
- While a result waits unconsumed, it holds steady and no new pair is taken.

Top module: `cwl_frac_mult`

## Requirements
- R1: Operands and result are W-bit two's complement fractions, with weight -1 on bit W-1 and 2^-(W-1-k) on bit k. With W=4, 0101 means 0.625, 0111 means 0.875 and 1000 means -1.
- R2: For every operand pair except -1 times -1, `out_result` equals bits 2W-2 down to W-1 of the signed integer product of the operand words. Equivalently, it is that product arithmetically shifted right by W-1.
- R3: The bits dropped are simply discarded, which rounds toward negative infinity. With W=4, 0001 times 1111 gives 1111 (-0.125), not 0000.
- R4: When both operands are 100…0, `out_result` is 0 followed by W-1 ones and `out_ovf` is 1.
- R5: For every other operand pair, `out_ovf` is 0.
- R6: A pair taken at a clock edge appears on `out_valid` and `out_result` right after that edge. With no new pair and `out_ready` high, `out_valid` drops after the next edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_result` and `out_ovf` stay unchanged. Operands presented during that time have no effect.
- R8: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_ovf` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | W | Multiplicand fraction |
| in_b | input | W | Multiplier fraction |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | W | Truncated W-bit product |
| out_ovf | output | 1 | Saturation occurred (-1 times -1) |

## Verification
With W=4, every one of the 256 operand pairs is streamed back to back. This sweep tells a correct sign-corrected array apart from one with a wrong correction constant or a wrong inverted term, because those errors show up only for certain sign combinations. Directed pairs add further distinctions:
- Negative tiny products separate truncation from rounding toward zero.
- The -1 times -1 pair separates saturation from wrap-around.
- A stalled consumer, with new operands pending, shows that held results are not overwritten.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  // Constant added by the sign-corrected array: 2^W + 2^(2W-1), for W up to 32.
  function automatic logic [63:0] bw_const(input int w);
    logic [63:0] c;
    c = '0;
    c[w] = 1'b1;
    c[2*w-1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/cwl_bw_array.sv
module cwl_bw_array #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  import cwl_pkg::*;
  localparam int P = 2 * W;

  logic [P-1:0] sums [W+1];
  logic [63:0]  cst;

  assign cst     = bw_const(W);
  assign sums[0] = cst[P-1:0];

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [P-1:0] row;
    always_comb begin
      row = '0;
      for (int j = 0; j < W; j++) begin
        if ((i == W - 1) != (j == W - 1))
          row[i + j] = ~(a[i] & b[j]);
        else
          row[i + j] = a[i] & b[j];
      end
    end
    assign sums[i + 1] = sums[i] + row;
  end

  assign prod = sums[W];
endmodule

// File: rtl/cwl_trunc_sat.sv
module cwl_trunc_sat #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   result,
  output logic           ovf
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  logic unused_low;
  assign unused_low = ^prod[W-2:0];

  // Only -1 x -1 makes the two top bits differ.
  assign ovf    = prod[2*W-1] ^ prod[2*W-2];
  assign result = ovf ? MAX_POS : prod[2*W-2:W-1];
endmodule

// File: rtl/cwl_frac_mult.sv
module cwl_frac_mult #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_ovf
);
  logic [2*W-1:0] prod;
  logic [W-1:0]   res_c;
  logic           ovf_c;
  logic           take;

  cwl_bw_array #(.W(W)) u_array (.a(in_a), .b(in_b), .prod(prod));
  cwl_trunc_sat #(.W(W)) u_trunc (.prod(prod), .result(res_c), .ovf(ovf_c));

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_c;
      out_ovf    <= ovf_c;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/cwl_frac_mult_chk.sv
module cwl_frac_mult_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_ovf
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R6
  AST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !out_valid); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_ovf))); // R7
  AST_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ovf) |-> (out_result == MAX_POS)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_ovf == ($past(in_a) == MIN_NEG && $past(in_b) == MIN_NEG))); // R5
endmodule

bind cwl_frac_mult cwl_frac_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_ovf(out_ovf)
);

// File: tb/cwl_frac_mult_test.sv
module cwl_frac_mult_test;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, in_valid, in_ready, out_valid, out_ready, out_ovf;
  logic [W-1:0] in_a, in_b, out_result;

  cwl_frac_mult #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_ovf(out_ovf)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= N / 2) ? v - N : v;
  endfunction

  function automatic int ref_res(input int a, input int b);
    int p, r;
    p = sx(a) * sx(b);
    r = p >>> (W - 1);
    if (r > N / 2 - 1) r = N / 2 - 1;
    return r & (N - 1);
  endfunction

  function automatic int ref_ovf(input int a, input int b);
    return (a == N / 2 && b == N / 2) ? 1 : 0;
  endfunction

  task automatic one_pair(input string tag, input int a, input int b, input int exp);
    @(negedge clk);
    in_a = a[W-1:0]; in_b = b[W-1:0]; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, int'(out_valid), 1);
    check({tag, " result"}, int'(out_result), exp);
    check({tag, " ovf"}, int'(out_ovf), ref_ovf(a, b));
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b1; in_a = '1; in_b = '1; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 out_result", int'(out_result), 0);
    check("R9 out_ovf", int'(out_ovf), 0);
    check("R8 in_ready after reset", int'(in_ready), 1);
    rst = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
  endtask

  task automatic test_examples();
    one_pair("R1 0.625*0.625", 4'b0101, 4'b0101, 4'b0011);
    one_pair("R1 0.875*0.875", 4'b0111, 4'b0111, 4'b0110);
    one_pair("R2 -1*0.875", 4'b1000, 4'b0111, 4'b1001);
    one_pair("R2 -0.5*-0.625", 4'b1100, 4'b1011, 4'b0010);
  endtask

  task automatic test_truncation();
    one_pair("R3 0.125*-0.125", 4'b0001, 4'b1111, 4'b1111);
    one_pair("R3 -0.375*0.125", 4'b1101, 4'b0001, 4'b1111);
    one_pair("R3 0.125*0.125", 4'b0001, 4'b0001, 4'b0000);
  endtask

  task automatic test_overflow();
    one_pair("R4 -1*-1", 4'b1000, 4'b1000, 4'b0111);
    check("R4 ovf raised", int'(out_ovf), 1);
  endtask

  task automatic test_exhaustive();
    @(negedge clk);
    out_ready = 1'b1;
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        in_a = a[W-1:0]; in_b = b[W-1:0]; in_valid = 1'b1;
        @(negedge clk);
        check("R2 sweep result", int'(out_result), ref_res(a, b));
        check((ref_ovf(a, b) == 1) ? "R4 sweep ovf" : "R5 sweep ovf",
              int'(out_ovf), ref_ovf(a, b));
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic test_latency();
    @(negedge clk);
    @(negedge clk);
    check("R6 idle before", int'(out_valid), 0);
    in_a = 4'b0110; in_b = 4'b0110; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 one-cycle valid", int'(out_valid), 1);
    check("R6 one-cycle result", int'(out_result), 4'b0100);
    @(negedge clk);
    check("R6 drained", int'(out_valid), 0);
  endtask

  task automatic test_backpressure();
    @(negedge clk);
    in_a = 4'b0101; in_b = 4'b0011; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check("R7 held valid", int'(out_valid), 1);
    check("R8 in_ready low when stalled", int'(in_ready), 0);
    in_a = 4'b1000; in_b = 4'b1000;
    repeat (2) @(negedge clk);
    check("R7 held result", int'(out_result), ref_res(5, 3));
    check("R7 held ovf", int'(out_ovf), 0);
    out_ready = 1'b1;
    #0;
    check("R8 in_ready with consumer ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next pair result", int'(out_result), 4'b0111);
    check("R7 next pair ovf", int'(out_ovf), 1);
    @(negedge clk);
    check("R6 empty after drain", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0; out_ready = 1'b1;
    test_reset();
    test_examples();
    test_truncation();
    test_overflow();
    test_latency();
    test_backpressure();
    test_exhaustive();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule